// File: doc/BRIEF.md
# Retired-Instruction Step Trigger

This block is a debug trigger that counts down once for each instruction retired in a privilege level the debugger has enabled. When the count reaches zero it raises a one-cycle fire pulse. Alongside the pulse it presents an action code, which tells downstream logic what to do: raise an exception, halt, start or stop trace, or emit trace. Carrying out that action is left to the rest of the core. A debugger uses the block mainly for single-stepping. It loads a count of one, enables the privilege levels it cares about, and resumes the hart.

Software reaches the trigger through one control word, written over a CSR-style write port and read back combinationally. An ownership bit can reserve the trigger for halt mode. While that bit is set, writes made outside halt mode are dropped.

A build parameter selects a reduced single-step variant. In that variant the count reads as a constant one, and the final step clears the four mode enables rather than counting down.

Top module: `instret_step_trigger`

## Requirements
- R1: After reset the control word reads 0x3000_0000, with type 3 in bits 31:28 and every other bit zero, and the fire output is low. The single-step variant reads 0x3000_0400, because its count field reads 1.
- R2: An accepted write stores the count from bits 23:10, the mode enables from bits 9:6 and the action code from bits 5:0. Read-back returns those fields, type 3 in bits 31:28, and zero in bits 26:24 whatever was written there.
- R3: Each enable bit belongs to one privilege level: bit 9 to machine (priv=3), bit 8 to hypervisor (priv=2), bit 7 to supervisor (priv=1) and bit 6 to user (priv=0). A retire strobe lowers the count by one only when the enable bit for the current privilege level is set. Otherwise the count is unchanged.
- R4: When a counted retirement takes the count from 1 to 0, the fire output is high for exactly the one cycle after that clock edge. During that cycle the action output equals the stored action field.
- R5: A count of 0 neither decrements nor fires again on later retirements until it is rewritten.
- R6: A write accepted in the same cycle as a retire strobe takes priority. That retirement is not counted and does not fire.
- R7: Ownership bit 27 changes only on writes made with halt_mode high. While the bit is set, writes with halt_mode low leave the whole control word unchanged, and writes with halt_mode high are still accepted.
- R8: A write with halt_mode low, while the ownership bit is clear, updates the other fields and leaves bit 27 reading 0.
- R9: In the single-step variant (ONE_SHOT=1) the count field always reads 1. A counted retirement fires once and clears bits 9:6, so later retirements do not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | XLEN | Control-word write data |
| halt_mode | input | 1 | High when the write comes from halt mode |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Privilege level of the retiring instruction (3 M, 2 H, 1 S, 0 U) |
| fire | output | 1 | One-cycle trigger pulse |
| fire_action | output | 6 | Action code for the pulse |
| cfg_rdata | output | XLEN | Control-word read-back |

## Verification
Every result the bench checks takes effect at the first clock edge after its stimulus. The count, the enables and the ownership bit are registers, and read-back is combinational from them. The fire pulse is registered in the same edge as the counted retirement. The bench therefore drives inputs on the falling edge, samples one time unit after the next rising edge, and clears the strobes before the following edge. Each check thus sees exactly the effect of one edge.

// File: rtl/instret_step_trigger.sv
module instret_step_trigger #(
  parameter int XLEN     = 32,
  parameter int CNT_W    = 14,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [XLEN-1:0] cfg_wdata,
  input  logic            halt_mode,
  input  logic            retire,
  input  logic [1:0]      priv,
  output logic            fire,
  output logic [5:0]      fire_action,
  output logic [XLEN-1:0] cfg_rdata
);
  localparam int ACT_W  = 6;
  localparam int EN_LO  = ACT_W;
  localparam int EN_HI  = EN_LO + 3;
  localparam int CNT_LO = EN_HI + 1;
  localparam int CNT_HI = CNT_LO + CNT_W - 1;
  localparam int OWN_B  = XLEN - 5;

  logic [3:0]       en_q;
  logic [ACT_W-1:0] act_q;
  logic             own_q;
  logic             fire_q;
  logic [CNT_W-1:0] cnt;
  logic             live, last;

  wire wr_ok = cfg_we && (halt_mode || !own_q);
  wire hit   = retire && en_q[priv];

  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[XLEN-1:XLEN-4], cfg_wdata[OWN_B-1:CNT_HI+1]};

  generate
    if (ONE_SHOT) begin : g_one
      logic unused_cnt;
      assign unused_cnt = ^cfg_wdata[CNT_HI:CNT_LO];
      assign cnt  = CNT_W'(1);
      assign live = hit;
      assign last = hit;

      assert_step_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> en_q == 4'd0);
    end else begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_ok)  cnt_q <= cfg_wdata[CNT_HI:CNT_LO];
        else if (live)   cnt_q <= cnt_q - 1'b1;
      end
      assign cnt  = cnt_q;
      assign live = hit && (cnt_q != '0);
      assign last = live && (cnt_q == CNT_W'(1));

      assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cnt_q != '0 && !wr_ok) |=> cnt_q == $past(cnt_q) - 1'b1);
      assert_zero_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !wr_ok) |=> cnt_q == '0);
      assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (cnt_q == $past(cfg_wdata[CNT_HI:CNT_LO])) && !fire);
      assert_fire_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> cnt_q == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      act_q  <= '0;
      own_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= last && !wr_ok;
      if (wr_ok) begin
        en_q  <= cfg_wdata[EN_HI:EN_LO];
        act_q <= cfg_wdata[ACT_W-1:0];
        if (halt_mode) own_q <= cfg_wdata[OWN_B];
      end else if (ONE_SHOT && live) begin
        en_q <= '0;
      end
    end
  end

  assign fire        = fire_q;
  assign fire_action = act_q;

  always_comb begin
    cfg_rdata                   = '0;
    cfg_rdata[XLEN-1 -: 4]      = 4'd3;
    cfg_rdata[OWN_B]            = own_q;
    cfg_rdata[CNT_HI:CNT_LO]    = cnt;
    cfg_rdata[EN_HI:EN_LO]      = en_q;
    cfg_rdata[ACT_W-1:0]        = act_q;
  end

  assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  assert_owner_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && cfg_we && !halt_mode) |=> $stable(cfg_rdata));
  assert_owner_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !halt_mode) |=> own_q == $past(own_q));
endmodule

// File: tb/instret_step_trigger_test.sv
module instret_step_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        halt_mode = 1'b0;
  logic        retire = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic        fire, fire1;
  logic [5:0]  act, act1;
  logic [31:0] rd, rd1;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  instret_step_trigger uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .halt_mode(halt_mode), .retire(retire), .priv(priv),
    .fire(fire), .fire_action(act), .cfg_rdata(rd));

  instret_step_trigger #(.ONE_SHOT(1'b1)) uut_one (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .halt_mode(halt_mode), .retire(retire), .priv(priv),
    .fire(fire1), .fire_action(act1), .cfg_rdata(rd1));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] w, input logic hm,
                      input logic ret, input logic [1:0] p);
    @(negedge clk);
    cfg_we = we; cfg_wdata = w; halt_mode = hm; retire = ret; priv = p;
    @(posedge clk);
    #1;
    cfg_we = 1'b0; retire = 1'b0; halt_mode = 1'b0;
  endtask

  function automatic logic [31:0] word(input int c, input logic [3:0] en, input logic [5:0] a);
    return (32'(c) << 10) | (32'(en) << 6) | 32'(a);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 reset word", rd, 32'h3000_0000);
    check("R1 reset fire", {31'd0, fire}, 32'd0);
    check("R1 variant reset word", rd1, 32'h3000_0400);

    step(1, 32'hFFFF_FFFF, 0, 0, 0);
    check("R2 all ones", rd, 32'h30FF_FFFF);
    step(1, 32'hA5A5_A5A5, 0, 0, 0);
    check("R2 pattern", rd, (32'hA5A5_A5A5 & 32'h00FF_FFFF) | 32'h3000_0000);
    check("R4 action out", {26'd0, act}, 32'h25);

    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 16; m++) begin
        step(1, word(3, 4'(m), 6'd0), 0, 0, 0);
        step(0, 0, 0, 1, 2'(p));
        check("R3 mode gate", (rd >> 10) & 32'h3FFF, m[p] ? 32'd2 : 32'd3);
      end
    end

    for (int n = 1; n <= 6; n++) begin
      step(1, word(n, 4'b1000, 6'(n % 5)), 0, 0, 0);
      for (int k = 1; k <= n; k++) begin
        step(0, 0, 0, 1, 2'd3);
        check("R4 fire timing", {31'd0, fire}, (k == n) ? 32'd1 : 32'd0);
        if (k == n) check("R4 fire action", {26'd0, act}, 32'(n % 5));
      end
      step(0, 0, 0, 0, 0);
      check("R4 single pulse", {31'd0, fire}, 32'd0);
      step(0, 0, 0, 1, 2'd3);
      check("R5 no refire", {31'd0, fire}, 32'd0);
      check("R5 stays zero", (rd >> 10) & 32'h3FFF, 32'd0);
    end

    step(1, word(5, 4'b1000, 0), 0, 0, 0);
    step(1, word(2, 4'b1000, 0), 0, 1, 2'd3);
    check("R6 write wins", (rd >> 10) & 32'h3FFF, 32'd2);
    step(1, word(1, 4'b1000, 0), 0, 1, 2'd3);
    check("R6 no fire on write", {31'd0, fire}, 32'd0);
    check("R6 count kept", (rd >> 10) & 32'h3FFF, 32'd1);
    step(0, 0, 0, 1, 2'd3);
    check("R6 later fire", {31'd0, fire}, 32'd1);

    step(1, word(7, 4'b0100, 1) | 32'h0800_0000, 1, 0, 0);
    check("R7 owner set", rd, 32'h3800_0000 | word(7, 4'b0100, 1));
    step(1, word(2, 4'b0001, 0), 0, 0, 0);
    check("R7 locked", rd, 32'h3800_0000 | word(7, 4'b0100, 1));
    step(1, word(4, 4'b0010, 2) | 32'h0800_0000, 1, 0, 0);
    check("R7 halt write", rd, 32'h3800_0000 | word(4, 4'b0010, 2));
    step(1, word(4, 4'b0010, 2), 1, 0, 0);
    check("R7 owner clear", rd, 32'h3000_0000 | word(4, 4'b0010, 2));
    step(1, word(9, 4'b0001, 3) | 32'h0800_0000, 0, 0, 0);
    check("R8 no owner from normal", rd, 32'h3000_0000 | word(9, 4'b0001, 3));

    step(1, word(0, 4'b0001, 1), 0, 0, 0);
    check("R9 count reads one", rd1, 32'h3000_0000 | word(1, 4'b0001, 1));
    step(0, 0, 0, 1, 2'd1);
    check("R9 other mode", {31'd0, fire1}, 32'd0);
    step(0, 0, 0, 1, 2'd0);
    check("R9 fires", {31'd0, fire1}, 32'd1);
    check("R9 enables cleared", rd1, 32'h3000_0000 | word(1, 4'b0000, 1));
    step(0, 0, 0, 1, 2'd0);
    check("R9 no refire", {31'd0, fire1}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule